// File: doc/BRIEF.md
# Character Dot Size Clock Generator

This block paces the pixel grid of an on-screen display character generator. It takes three clock-source ticks: a data slicer tick, an oscillator tick and a main-clock tick. Each tick is a one-cycle enable in the system clock domain. The block keeps only the source that has been chosen. A pre-divider groups the chosen ticks in twos or threes, and one such group is the base period, called TC. The block then emits a one-cycle `dot_stb` at the end of every 1, 2 or 3 TC. This strobe marks where the character engine moves to the next horizontal dot. The block also takes an asynchronous horizontal sync input and synchronises it. On every rising sync edge it restarts the horizontal timing. It counts those edges to emit a one-cycle `line_stb` whenever the character engine should move to its next dot row.

All settings are captured only on a `blk_start` pulse, which marks the start of a display block: the source choice, the divide-by-3 request, the 4-bit size field and the double-scan flag. Between two block starts, changes on those inputs have no effect, so a dot never changes size part-way through a character. A closed-caption mode input is applied live and suppresses divide-by-3. In double-scan mode the dot height in scan lines is twice its normal value.

Three state machines sit inside. The sync tracker has the states SY_LOW and SY_HIGH. It moves SY_LOW→SY_HIGH when the synchronised level is 1, and that move raises the one-cycle line event. It moves SY_HIGH→SY_LOW when the level is 0. The pre-divider has the states PD_0, PD_1 and PD_2. Each chosen tick moves PD_0→PD_1. From PD_1 a tick moves to PD_2 when divide-by-3 is in effect. Otherwise the tick moves PD_1→PD_0 and completes one TC. A tick always moves PD_2→PD_0 and completes one TC. A restart from a line event or a block start forces PD_0.

Top module: `osd_dot_size_gen`

## Requirements
- R1: In reset and after reset, both strobes are 0. Until the first `blk_start`, the block behaves as the slicer source, divide-by-2, a width of 1 TC, a height of one scan line and normal scan.
- R2: `src_sel` selects the counted tick: 00 slicer, 01 oscillator, 10 main, 11 main. Ticks from the sources not selected have no effect.
- R3: `prediv3`=1 makes one TC equal three selected ticks. `prediv3`=0 makes one TC equal two selected ticks.
- R4: While `cc_mode` is 1, one TC is two ticks whatever `prediv3` was. When `cc_mode` drops, the captured divide-by-3 request takes effect again without a new block start.
- R5: `size_field[1:0]` sets the dot width: 00 = 1 TC, 01 = 2 TC, 10 = 3 TC, 11 = 3 TC. `dot_stb` is a single-cycle pulse at the end of each dot.
- R6: `size_field[3:2]` sets the dot height in line events: 00 = 1 (half-line size), 01 = 2 (one line per field), 10 = 4, 11 = 6. `line_stb` pulses on the line event that completes the count.
- R7: With `bi_scan`=1 captured, the heights of R6 double to 2, 4, 8 and 12 line events.
- R8: A rising level of `hsync` gives exactly one line event, however long the level stays high. A `line_stb` caused by it is seen 4 cycles after the `hsync` rise is driven (two synchroniser stages, the event register and the strobe register).
- R9: Each line event restarts the pre-divider and the dot counter. The first `dot_stb` of a line comes exactly width × divide selected ticks after the restart edge, which is the cycle in which a half-line `line_stb` appears.
- R10: The settings are captured only when `blk_start` is 1. A `blk_start` also clears the horizontal and vertical counters and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slicer | input | 1 | Data slicer source tick |
| tick_osc | input | 1 | Oscillator source tick |
| tick_main | input | 1 | Main-clock source tick |
| src_sel | input | 2 | Source choice, captured at block start |
| prediv3 | input | 1 | Divide-by-3 request, captured at block start |
| cc_mode | input | 1 | Closed-caption mode, live, forces divide-by-2 |
| size_field | input | 4 | [1:0] dot width code, [3:2] dot height code |
| bi_scan | input | 1 | Double-scan mode, captured at block start |
| blk_start | input | 1 | Display block start pulse |
| hsync | input | 1 | Asynchronous horizontal sync level |
| dot_stb | output | 1 | Horizontal dot advance strobe |
| line_stb | output | 1 | Vertical dot row advance strobe |

## Verification
A wrong pre-divider or dot-counter state moves the next `dot_stb` out of its place. This shows up within one dot period, at most nine selected ticks, and every later dot in the line keeps the same shift. A fault in the line count or the sync tracker shows up as a missing, extra or late `line_stb` within at most twelve sync edges. A sync tracker stuck high stops all later line strobes. The cycle-exact reference model catches any of these on the first clock where the strobes differ. Counts of dot gaps and line strobes then tie each fault to the setting that exposed it.

// File: rtl/osd_dot_pkg.sv
package osd_dot_pkg;

    // Source choice; both upper codes select the main-clock tick
    typedef enum logic [1:0] {
        SRC_SLICER   = 2'b00,
        SRC_OSC      = 2'b01,
        SRC_MAIN     = 2'b10,
        SRC_MAIN_ALT = 2'b11
    } clk_src_e;

    // Horizontal width codes; the top code repeats the widest size
    typedef enum logic [1:0] {
        HW_1TC     = 2'b00,
        HW_2TC     = 2'b01,
        HW_3TC     = 2'b10,
        HW_3TC_ALT = 2'b11
    } hwidth_e;

    // Vertical height codes
    typedef enum logic [1:0] {
        VH_HALF  = 2'b00,
        VH_ONE   = 2'b01,
        VH_TWO   = 2'b10,
        VH_THREE = 2'b11
    } vheight_e;

    localparam int MAX_HWIDTH  = 3;
    localparam int MAX_VLINES  = 12;
    localparam int HW_W        = $clog2(MAX_HWIDTH + 1);
    localparam int VL_W        = $clog2(MAX_VLINES + 1);

    typedef struct packed {
        clk_src_e src;
        logic     div3;
        hwidth_e  hw;
        vheight_e vh;
        logic     bi_scan;
    } dot_cfg_t;

    localparam dot_cfg_t CFG_RESET = '{
        src:     SRC_SLICER,
        div3:    1'b0,
        hw:      HW_1TC,
        vh:      VH_HALF,
        bi_scan: 1'b0
    };

    // Dot width in base periods
    function automatic logic [HW_W-1:0] hwidth_tc(input hwidth_e hw);
        logic [HW_W-1:0] n;
        unique case (hw)
            HW_1TC:     n = HW_W'(1);
            HW_2TC:     n = HW_W'(2);
            HW_3TC:     n = HW_W'(3);
            HW_3TC_ALT: n = HW_W'(3);
            default:    n = HW_W'(3);
        endcase
        return n;
    endfunction

    // Dot height in line events, doubled in double-scan mode
    function automatic logic [VL_W-1:0] vheight_lines(input vheight_e vh, input logic bi);
        logic [VL_W-1:0] n;
        unique case (vh)
            VH_HALF:  n = VL_W'(1);
            VH_ONE:   n = VL_W'(2);
            VH_TWO:   n = VL_W'(4);
            VH_THREE: n = VL_W'(6);
            default:  n = VL_W'(6);
        endcase
        if (bi) begin
            n = n << 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/osd_hsync_sync.sv
module osd_hsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    output logic hs_event
);

    typedef enum logic {
        SY_LOW  = 1'b0,
        SY_HIGH = 1'b1
    } sync_state_e;

    logic [STAGES-1:0] chain;
    logic              level;
    sync_state_e       state_q;
    sync_state_e       state_d;
    logic              event_d;

    // Synchroniser chain, one flop per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[0] <= 1'b0;
                end else begin
                    chain[0] <= hsync_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    end

    assign level = chain[STAGES-1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        event_d = 1'b0;
        unique case (state_q)
            SY_LOW: begin
                if (level) begin
                    state_d = SY_HIGH;
                    event_d = 1'b1;
                end
            end
            SY_HIGH: begin
                if (!level) begin
                    state_d = SY_LOW;
                end
            end
            default: state_d = SY_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SY_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_event <= 1'b0;
        end else begin
            hs_event <= event_d;
        end
    end

    // R8: one event per rising level, never two in a row
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        hs_event |=> !hs_event);

    // R8: an event only follows a high synchronised level
    a_r8_event_from_level: assert property (@(posedge clk) disable iff (!rst_n)
        hs_event |-> $past(level));

endmodule

// File: rtl/osd_hdot_div.sv
module osd_hdot_div
    import osd_dot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_slicer,
    input  logic     tick_osc,
    input  logic     tick_main,
    input  clk_src_e src,
    input  logic     div3,
    input  hwidth_e  hw,
    input  logic     restart,
    output logic     dot_stb
);

    typedef enum logic [1:0] {
        PD_0 = 2'b00,
        PD_1 = 2'b01,
        PD_2 = 2'b10
    } pd_state_e;

    pd_state_e       pd_q;
    pd_state_e       pd_d;
    logic            tc_done;
    logic            tick_sel;
    logic [HW_W-1:0] dc_q;
    logic [HW_W-1:0] hw_lim;
    logic            dot_d;

    // Source multiplexer
    always_comb begin
        unique case (src)
            SRC_SLICER:   tick_sel = tick_slicer;
            SRC_OSC:      tick_sel = tick_osc;
            SRC_MAIN:     tick_sel = tick_main;
            SRC_MAIN_ALT: tick_sel = tick_main;
            default:      tick_sel = tick_main;
        endcase
    end

    assign hw_lim = hwidth_tc(hw);

    // Pre-divider next state
    always_comb begin
        pd_d    = pd_q;
        tc_done = 1'b0;
        unique case (pd_q)
            PD_0: begin
                if (tick_sel) begin
                    pd_d = PD_1;
                end
            end
            PD_1: begin
                if (tick_sel) begin
                    if (div3) begin
                        pd_d = PD_2;
                    end else begin
                        pd_d    = PD_0;
                        tc_done = 1'b1;
                    end
                end
            end
            PD_2: begin
                if (tick_sel) begin
                    pd_d    = PD_0;
                    tc_done = 1'b1;
                end
            end
            default: pd_d = PD_0;
        endcase
    end

    // Pre-divider state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= PD_0;
        end else if (restart) begin
            pd_q <= PD_0;
        end else begin
            pd_q <= pd_d;
        end
    end

    assign dot_d = tc_done && (dc_q == hw_lim - HW_W'(1));

    // Dot counter and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q    <= '0;
            dot_stb <= 1'b0;
        end else if (restart) begin
            dc_q    <= '0;
            dot_stb <= 1'b0;
        end else begin
            dot_stb <= dot_d;
            if (tc_done) begin
                dc_q <= dot_d ? '0 : dc_q + HW_W'(1);
            end
        end
    end

    // R3: a dot needs at least two ticks, so strobes never touch
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        dot_stb |=> !dot_stb);

    // R9: a restart clears the strobe and the pre-divider phase
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!dot_stb && pd_q == PD_0));

    // R4: without divide-by-3 the second tick closes the base period
    a_r4_div2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!div3 && pd_q == PD_1 && tick_sel && !restart) |=> (pd_q == PD_0));

    // R2: a strobe is always caused by a tick of the selected source
    a_r2_dot_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        dot_stb |-> $past(tick_sel));

endmodule

// File: rtl/osd_vdot_div.sv
module osd_vdot_div
    import osd_dot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hs_event,
    input  logic     clear,
    input  vheight_e vh,
    input  logic     bi_scan,
    output logic     line_stb
);

    logic [VL_W-1:0] vc_q;
    logic [VL_W-1:0] v_lim;
    logic            last_line;

    assign v_lim     = vheight_lines(vh, bi_scan);
    assign last_line = (vc_q >= v_lim - VL_W'(1));

    // Line event counter and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vc_q     <= '0;
            line_stb <= 1'b0;
        end else if (clear) begin
            vc_q     <= '0;
            line_stb <= 1'b0;
        end else begin
            line_stb <= hs_event && last_line;
            if (hs_event) begin
                vc_q <= last_line ? '0 : vc_q + VL_W'(1);
            end
        end
    end

    // R6: each row strobe is caused by a line event
    a_r6_line_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |-> $past(hs_event));

    // R10: a block start clears the strobe
    a_r10_clear_line: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !line_stb);

    // R7: the count never passes the largest height
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        vc_q < VL_W'(MAX_VLINES));

endmodule

// File: rtl/osd_dot_size_gen.sv
module osd_dot_size_gen
    import osd_dot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_slicer,
    input  logic       tick_osc,
    input  logic       tick_main,
    input  logic [1:0] src_sel,
    input  logic       prediv3,
    input  logic       cc_mode,
    input  logic [3:0] size_field,
    input  logic       bi_scan,
    input  logic       blk_start,
    input  logic       hsync,
    output logic       dot_stb,
    output logic       line_stb
);

    dot_cfg_t cfg_q;
    logic     hs_event;
    logic     div3_eff;
    logic     h_restart;

    // Settings captured at the start of each display block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (blk_start) begin
            cfg_q <= '{
                src:     clk_src_e'(src_sel),
                div3:    prediv3,
                hw:      hwidth_e'(size_field[1:0]),
                vh:      vheight_e'(size_field[3:2]),
                bi_scan: bi_scan
            };
        end
    end

    // Closed-caption mode vetoes the divide-by-3 request live
    assign div3_eff  = cfg_q.div3 & ~cc_mode;
    assign h_restart = hs_event | blk_start;

    osd_hsync_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_in (hsync),
        .hs_event (hs_event)
    );

    osd_hdot_div u_hdiv (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_slicer (tick_slicer),
        .tick_osc    (tick_osc),
        .tick_main   (tick_main),
        .src         (cfg_q.src),
        .div3        (div3_eff),
        .hw          (cfg_q.hw),
        .restart     (h_restart),
        .dot_stb     (dot_stb)
    );

    osd_vdot_div u_vdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_event (hs_event),
        .clear    (blk_start),
        .vh       (cfg_q.vh),
        .bi_scan  (cfg_q.bi_scan),
        .line_stb (line_stb)
    );

    // R10: settings hold between block starts
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> $stable(cfg_q));

    // R10: a block start silences the dot strobe on the next cycle
    a_r10_blk_clears_dot: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !dot_stb);

endmodule

// File: tb/test_osd_dot_size_gen.sv
module test_osd_dot_size_gen;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N     = 2;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_slicer = 1'b0;
    logic       tick_osc = 1'b0;
    logic       tick_main = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       prediv3 = 1'b0;
    logic       cc_mode = 1'b0;
    logic [3:0] size_field = 4'b0000;
    logic       bi_scan = 1'b0;
    logic       blk_start = 1'b0;
    logic       hsync = 1'b0;
    logic       dot_stb;
    logic       line_stb;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    tcnt = 0;
    bit    started = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    bit m_sh [SYNC_N];
    bit m_high = 0, m_hs = 0, m_dot = 0, m_line = 0;
    int m_pd = 0, m_dc = 0, m_vc = 0;
    int c_src = 0, c_h = 0, c_v = 0;
    bit c_div3 = 0, c_bi = 0;

    osd_dot_size_gen #(.SYNC_STAGES(SYNC_N)) i_osd_dot_size_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_slicer (tick_slicer),
        .tick_osc    (tick_osc),
        .tick_main   (tick_main),
        .src_sel     (src_sel),
        .prediv3     (prediv3),
        .cc_mode     (cc_mode),
        .size_field  (size_field),
        .bi_scan     (bi_scan),
        .blk_start   (blk_start),
        .hsync       (hsync),
        .dot_stb     (dot_stb),
        .line_stb    (line_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running source ticks: slicer every cycle, oscillator every 2nd, main every 3rd
    always @(negedge clk) begin
        tcnt        = tcnt + 1;
        tick_slicer = 1'b1;
        tick_osc    = (tcnt % 2) == 0;
        tick_main   = (tcnt % 3) == 0;
    end

    // Behavioural reference model
    always @(posedge clk) begin
        bit tk, restart, div3, last, n_dot, n_line, n_hs;
        int lim, hl, vl;
        if (!rst_n) begin
            for (int i = 0; i < SYNC_N; i++) m_sh[i] = 0;
            m_high = 0; m_hs = 0; m_dot = 0; m_line = 0;
            m_pd = 0; m_dc = 0; m_vc = 0;
            c_src = 0; c_h = 0; c_v = 0; c_div3 = 0; c_bi = 0;
        end else begin
            tk = (c_src == 0) ? tick_slicer : (c_src == 1) ? tick_osc : tick_main;
            restart = m_hs || blk_start;
            div3 = c_div3 && !cc_mode;
            lim = div3 ? 3 : 2;
            hl = (c_h == 0) ? 1 : (c_h == 1) ? 2 : 3;
            vl = (c_v == 0) ? 1 : (c_v == 1) ? 2 : (c_v == 2) ? 4 : 6;
            if (c_bi) vl = vl * 2;
            n_dot = 0;
            if (restart) begin
                m_pd = 0; m_dc = 0;
            end else if (tk) begin
                if (m_pd + 1 >= lim) begin
                    m_pd = 0;
                    if (m_dc == hl - 1) begin m_dc = 0; n_dot = 1; end
                    else m_dc = m_dc + 1;
                end else begin
                    m_pd = m_pd + 1;
                end
            end
            n_line = 0;
            if (blk_start) m_vc = 0;
            else if (m_hs) begin
                if (m_vc >= vl - 1) begin m_vc = 0; n_line = 1; end
                else m_vc = m_vc + 1;
            end
            last = m_sh[SYNC_N-1];
            n_hs = !m_high && last;
            m_high = last;
            for (int i = SYNC_N - 1; i > 0; i--) m_sh[i] = m_sh[i-1];
            m_sh[0] = hsync;
            if (blk_start) begin
                c_src = src_sel; c_div3 = prediv3; c_h = size_field[1:0];
                c_v = size_field[3:2]; c_bi = bi_scan;
            end
            m_dot = n_dot; m_line = n_line; m_hs = n_hs;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            n_cmp = n_cmp + 1;
            if (dot_stb !== m_dot || line_stb !== m_line) begin
                n_bad = n_bad + 1;
                $display("FAIL %s: dot/line actual %b/%b expected %b/%b at cycle %0d",
                         cur_tag, dot_stb, line_stb, m_dot, m_line, cyc);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check_eq(input int act, input int exp, input string tag);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [1:0] s, input logic d3,
                             input logic [3:0] sz, input logic bi);
        @(negedge clk);
        src_sel = s; prediv3 = d3; size_field = sz; bi_scan = bi; blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
    endtask

    // Gap in cycles between two consecutive dot strobes
    task automatic check_gap(input int exp, input string tag);
        int n;
        cur_tag = tag;
        n = 0;
        while (!dot_stb && n < 400) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!dot_stb && n < 400);
        check_eq(n, exp, tag);
    endtask

    // Drive sync pulses and count row strobes
    task automatic count_lines(input int pulses, input int exp, input string tag);
        int n;
        cur_tag = tag;
        n = 0;
        for (int p = 0; p < pulses; p++) begin
            hsync = 1'b1;
            repeat (3) begin @(negedge clk); if (line_stb) n++; end
            hsync = 1'b0;
            repeat (9) begin @(negedge clk); if (line_stb) n++; end
        end
        repeat (8) begin @(negedge clk); if (line_stb) n++; end
        check_eq(n, exp, tag);
    endtask

    // Sync-to-strobe latency and first dot phase after a line event
    task automatic check_line_phase(input int exp_dot, input string tag);
        int n;
        cur_tag = tag;
        @(negedge clk);
        hsync = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!line_stb && n < 50);
        check_eq(n, SYNC_N + 2, {tag, " latency"});
        n = 0;
        do begin @(negedge clk); n++; end while (!dot_stb && n < 100);
        check_eq(n, exp_dot, {tag, " first dot"});
        repeat (4) @(negedge clk);
        hsync = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_tag = "R1 reset";
        check_eq(int'(dot_stb), 0, "R1 dot_stb in reset");
        check_eq(int'(line_stb), 0, "R1 line_stb in reset");
        rst_n = 1'b1;
        started = 1'b1;
        check_gap(2, "R1 default slicer div2 1TC");

        apply_cfg(2'b00, 1'b1, 4'b0000, 1'b0);
        check_gap(3, "R3 divide by 3");
        apply_cfg(2'b00, 1'b0, 4'b0000, 1'b0);
        check_gap(2, "R3 divide by 2");
        apply_cfg(2'b00, 1'b1, 4'b0001, 1'b0);
        check_gap(6, "R5 width 2TC div3");
        apply_cfg(2'b00, 1'b0, 4'b0010, 1'b0);
        check_gap(6, "R5 width 3TC div2");
        apply_cfg(2'b00, 1'b0, 4'b0011, 1'b0);
        check_gap(6, "R5 width code 11");

        apply_cfg(2'b01, 1'b0, 4'b0000, 1'b0);
        check_gap(4, "R2 oscillator source");
        apply_cfg(2'b10, 1'b0, 4'b0001, 1'b0);
        check_gap(12, "R2 main source 2TC");
        apply_cfg(2'b11, 1'b0, 4'b0000, 1'b0);
        check_gap(6, "R2 code 11 main");

        cc_mode = 1'b1;
        apply_cfg(2'b00, 1'b1, 4'b0010, 1'b0);
        check_gap(6, "R4 cc forces div2");
        cc_mode = 1'b0;
        check_gap(9, "R4 cc released div3");

        @(negedge clk);
        src_sel = 2'b01; prediv3 = 1'b0; size_field = 4'b1100; bi_scan = 1'b1;
        check_gap(9, "R10 no capture without block start");
        apply_cfg(2'b01, 1'b0, 4'b0000, 1'b0);
        check_gap(4, "R10 captured at block start");

        apply_cfg(2'b00, 1'b1, 4'b0010, 1'b0);
        check_line_phase(9, "R8 R9 div3 3TC");
        apply_cfg(2'b00, 1'b0, 4'b0000, 1'b0);
        check_line_phase(2, "R9 div2 1TC");

        apply_cfg(2'b00, 1'b0, 4'b0000, 1'b0);
        count_lines(6, 6, "R6 half line");
        apply_cfg(2'b00, 1'b0, 4'b0100, 1'b0);
        count_lines(6, 3, "R6 one line");
        apply_cfg(2'b00, 1'b0, 4'b1000, 1'b0);
        count_lines(8, 2, "R6 two lines");
        apply_cfg(2'b00, 1'b0, 4'b1100, 1'b0);
        count_lines(12, 2, "R6 three lines");
        apply_cfg(2'b00, 1'b0, 4'b0100, 1'b1);
        count_lines(8, 2, "R7 double scan one line");
        apply_cfg(2'b00, 1'b0, 4'b1100, 1'b1);
        count_lines(24, 2, "R7 double scan three lines");

        apply_cfg(2'b00, 1'b0, 4'b0100, 1'b0);
        count_lines(1, 0, "R10 first of two");
        apply_cfg(2'b00, 1'b0, 4'b0100, 1'b0);
        count_lines(1, 0, "R10 count cleared by block start");

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule